// File: doc/BRIEF.md
# Strided Blit Descriptor Generator

This block turns a two-dimensional copy request into a chain of scatter-gather DMA descriptors. A request gives a system-memory start address, a frame-buffer start address, a line length in bytes, a number of lines, an unsigned memory stride and a signed frame-buffer stride. A negative frame-buffer stride walks the frame buffer upward, so an image can be flipped vertically while it is copied. Each line is cut into pieces so that no piece crosses a 4 KiB page of system memory. Each piece becomes one descriptor.

Descriptors leave one at a time on a valid/ready stream. Each one carries four 32-bit words: memory address, device address, byte count and a link to the previous descriptor. The chain is built in reverse. The first descriptor produced is the tail of the chain, and every later descriptor points back to the slot of the one produced before it. Slots are 16 bytes apart, starting at a parameter base.

A count-only mode walks the same request without producing output and reports only how many descriptors a real pass would need. The caller can use this to size the descriptor storage before the real pass. A request that breaks the size, stride or alignment rules is refused with a one-cycle error pulse.

Top module: `blit_desc_gen`

## Requirements
- R1: Each descriptor's byte count is the smaller of the bytes still left in the current line and the bytes left before the next 4 KiB boundary of its memory address. A descriptor therefore never spans a page and never has a zero size.
- R2: After a descriptor, the memory cursor and the frame-buffer cursor both move on by its byte count. Line n (counted from 0) starts at mem_addr + n*mem_stride and at fb_addr + n*fb_stride. The frame-buffer stride is a two's-complement value and may be negative.
- R3: The descriptor outputs give the memory address, the device (frame-buffer) address, the byte count zero-extended to 32 bits, and the link word.
- R4: The first descriptor of a request has the link value 0x0000_0002, which is only the end-of-chain bit (bit 1). Descriptor k (k >= 1, counted from 0) has the link value LINK_BASE + 16*(k-1).
- R5: A request is refused if it has zero lines, a zero line length, more than 2048 lines, a memory stride above 8192, or a memory stride that exceeds the line length by 4096 or more.
- R6: A request is refused unless mem_addr and mem_stride are multiples of 16 and fb_addr and fb_stride are multiples of 4.
- R7: A request is refused if the memory stride is below the line length, or if the magnitude of the frame-buffer stride is below the line length.
- R8: A refused request raises error for exactly the one cycle after it is accepted. It produces no descriptor and no done.
- R9: While desc_valid is high and desc_ready is low, desc_valid stays high and all four descriptor words hold their values.
- R10: done is high for exactly one cycle, in the cycle after the last descriptor is taken. desc_count then equals the number of descriptors in the request.
- R11: In count-only mode desc_valid stays low. The block counts one descriptor per clock, and done rises in cycle N+1 after acceptance, where N is the total, with desc_count = N.
- R12: req_ready is high only while the block is idle (also after reset). A request offered while it is busy is not accepted and does not change the chain being produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_mem_addr | input | 32 | System-memory start address |
| req_fb_addr | input | 32 | Frame-buffer start address |
| req_line_len | input | 16 | Bytes per line |
| req_lines | input | 16 | Number of lines |
| req_mem_stride | input | 16 | System-memory distance between lines |
| req_fb_stride | input | 32 | Signed frame-buffer distance between lines |
| req_count_only | input | 1 | Count descriptors without producing them |
| desc_valid | output | 1 | Descriptor on the outputs |
| desc_ready | input | 1 | Consumer takes the descriptor |
| desc_mem_addr | output | 32 | Descriptor system-memory address |
| desc_dev_addr | output | 32 | Descriptor frame-buffer address |
| desc_size | output | 32 | Descriptor byte count |
| desc_link | output | 32 | Link to the previous descriptor, or the end-of-chain mark |
| done | output | 1 | One-cycle pulse after the last descriptor |
| error | output | 1 | One-cycle pulse for a refused request |
| desc_count | output | 32 | Descriptors produced or counted for the last request |

## Verification
The hardest case to reach is a line that both begins partway into a page and ends exactly on a page boundary, while the consumer stalls. The walker must then detect the end of the line and the page limit in the same step, move to the next line's start, and keep the stalled descriptor stable. The stimulus places line starts at offsets such as 0xF00 with lengths that reach exactly 0x1000. It also uses lines longer than a page, so that one line spans three pages. A pseudo-random pattern drives desc_ready so that stalls fall on these split points. A further run sends the maximum of 2048 lines in count-only mode to check the counter and the done timing at that limit.

// File: rtl/blit_desc_pkg.sv
package blit_desc_pkg;

  localparam int unsigned WORD_W = 32;
  localparam logic [WORD_W-1:0] TAIL_LINK = 32'h0000_0002;  // end-of-chain bit only

  typedef enum logic {WALK_IDLE, WALK_RUN} walk_state_e;

  typedef struct packed {
    logic [WORD_W-1:0] mem_addr;
    logic [WORD_W-1:0] fb_addr;
    logic [15:0]       line_len;
    logic [15:0]       lines;
    logic [15:0]       mem_stride;
    logic [WORD_W-1:0] fb_stride;
    logic              count_only;
  } blit_req_t;

  typedef struct packed {
    logic [WORD_W-1:0] mem;
    logic [WORD_W-1:0] dev;
    logic [WORD_W-1:0] size;
    logic [WORD_W-1:0] link;
  } blit_desc_t;

  // bytes for the next piece: limited by the line remainder and the page remainder
  function automatic logic [WORD_W-1:0] chunk_bytes(input logic [WORD_W-1:0] cur,
                                                    input logic [WORD_W-1:0] left,
                                                    input int unsigned       pbits);
    logic [WORD_W-1:0] page;
    logic [WORD_W-1:0] room;
    page = 32'd1 << pbits;
    room = page - (cur & (page - 32'd1));
    return (left < room) ? left : room;
  endfunction

  // reverse chain: piece 0 is the tail, later pieces point at the slot before
  function automatic logic [WORD_W-1:0] desc_link(input logic [WORD_W-1:0] idx,
                                                  input logic [WORD_W-1:0] base);
    return (idx == '0) ? TAIL_LINK : base + ((idx - 32'd1) << 4);
  endfunction

endpackage

// File: rtl/blit_req_check.sv
module blit_req_check #(
  parameter int unsigned MAX_LINES   = 2048,
  parameter int unsigned MAX_MSTRIDE = 8192,
  parameter int unsigned PAGE_BITS   = 12
) (
  input  logic [31:0] mem_addr,
  input  logic [31:0] fb_addr,
  input  logic [15:0] line_len,
  input  logic [15:0] lines,
  input  logic [15:0] mem_stride,
  input  logic [31:0] fb_stride,
  output logic        bad_size,
  output logic        bad_stride,
  output logic        bad_align,
  output logic        req_ok
);
  localparam logic [31:0] PAGE_BYTES = 32'd1 << PAGE_BITS;
  localparam logic [31:0] LINES_LIM  = 32'(MAX_LINES);
  localparam logic [31:0] MSTR_LIM   = 32'(MAX_MSTRIDE);

  logic [31:0] len32, lines32, ms32, fb_mag, gap;

  always_comb begin
    len32   = {16'd0, line_len};
    lines32 = {16'd0, lines};
    ms32    = {16'd0, mem_stride};
    fb_mag  = fb_stride[31] ? (32'd0 - fb_stride) : fb_stride;
    gap     = ms32 - len32;
  end

  // R5: empty or oversized requests
  assign bad_size = (lines32 == 0) || (len32 == 0) || (lines32 > LINES_LIM) ||
                    (ms32 > MSTR_LIM) || ((ms32 >= len32) && (gap >= PAGE_BYTES));
  // R7: strides must cover a whole line
  assign bad_stride = (ms32 < len32) || (fb_mag < len32);
  // R6: alignment of addresses and strides
  assign bad_align = (mem_addr[3:0] != 4'd0) || (mem_stride[3:0] != 4'd0) ||
                     (fb_addr[1:0] != 2'd0) || (fb_stride[1:0] != 2'd0);

  assign req_ok = !(bad_size || bad_stride || bad_align);

endmodule

// File: rtl/blit_walk.sv
module blit_walk
  import blit_desc_pkg::*;
#(
  parameter int unsigned     PAGE_BITS = 12,
  parameter logic [31:0]     LINK_BASE = 32'h0001_0000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  blit_req_t  req,
  input  logic       out_ready,
  output logic       busy,
  output logic       emit_valid,
  output blit_desc_t desc,
  output logic       walk_done,
  output logic [31:0] count
);
  localparam logic [32:0] PAGE33 = 33'd1 << PAGE_BITS;
  localparam logic [31:0] PMASK  = (32'd1 << PAGE_BITS) - 32'd1;

  walk_state_e state;
  logic        mode_cnt;
  logic [31:0] mem_cur, fb_cur, mem_line, fb_line, mstride, fstride;
  logic [15:0] left, line_len, lines_left;

  // named internal events
  logic [31:0] piece;
  logic        step, line_end, last_piece;
  logic [31:0] next_mem_line, next_fb_line;

  assign piece         = chunk_bytes(mem_cur, {16'd0, left}, PAGE_BITS);
  assign step          = (state == WALK_RUN) && (mode_cnt || out_ready);
  assign line_end      = (piece == {16'd0, left});
  assign last_piece    = line_end && (lines_left == 16'd1);
  assign next_mem_line = mem_line + mstride;
  assign next_fb_line  = fb_line + fstride;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= WALK_IDLE;
      mode_cnt   <= 1'b0;
      mem_cur    <= '0;
      fb_cur     <= '0;
      mem_line   <= '0;
      fb_line    <= '0;
      mstride    <= '0;
      fstride    <= '0;
      left       <= '0;
      line_len   <= '0;
      lines_left <= '0;
      count      <= '0;
      walk_done  <= 1'b0;
    end else begin
      walk_done <= step && last_piece;
      if (start && state == WALK_IDLE) begin
        state      <= WALK_RUN;
        mode_cnt   <= req.count_only;
        mem_cur    <= req.mem_addr;
        mem_line   <= req.mem_addr;
        fb_cur     <= req.fb_addr;
        fb_line    <= req.fb_addr;
        mstride    <= {16'd0, req.mem_stride};
        fstride    <= req.fb_stride;
        left       <= req.line_len;
        line_len   <= req.line_len;
        lines_left <= req.lines;
        count      <= '0;
      end else if (step) begin
        count <= count + 32'd1;
        if (last_piece) begin
          state <= WALK_IDLE;
        end else if (line_end) begin
          mem_line   <= next_mem_line;
          mem_cur    <= next_mem_line;
          fb_line    <= next_fb_line;
          fb_cur     <= next_fb_line;
          left       <= line_len;
          lines_left <= lines_left - 16'd1;
        end else begin
          mem_cur <= mem_cur + piece;
          fb_cur  <= fb_cur + piece;
          left    <= left - piece[15:0];
        end
      end
    end
  end

  assign busy       = (state == WALK_RUN);
  assign emit_valid = busy && !mode_cnt;
  assign desc.mem   = mem_cur;
  assign desc.dev   = fb_cur;
  assign desc.size  = piece;
  assign desc.link  = desc_link(count, LINK_BASE);

  // R1: a piece is non-empty and stays inside its page
  a_r1_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    emit_valid |-> (desc.size != 0) &&
                   (({1'b0, desc.mem & PMASK} + {1'b0, desc.size}) <= PAGE33));

  // R9: a stalled descriptor does not move
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_valid && !out_ready) |=> (emit_valid && $stable(desc)));

  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> !walk_done);

endmodule

// File: rtl/blit_desc_gen.sv
module blit_desc_gen
  import blit_desc_pkg::*;
#(
  parameter int unsigned MAX_LINES   = 2048,
  parameter int unsigned MAX_MSTRIDE = 8192,
  parameter int unsigned PAGE_BITS   = 12,
  parameter logic [31:0] LINK_BASE   = 32'h0001_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_mem_addr,
  input  logic [31:0] req_fb_addr,
  input  logic [15:0] req_line_len,
  input  logic [15:0] req_lines,
  input  logic [15:0] req_mem_stride,
  input  logic [31:0] req_fb_stride,
  input  logic        req_count_only,
  output logic        desc_valid,
  input  logic        desc_ready,
  output logic [31:0] desc_mem_addr,
  output logic [31:0] desc_dev_addr,
  output logic [31:0] desc_size,
  output logic [31:0] desc_link,
  output logic        done,
  output logic        error,
  output logic [31:0] desc_count
);
  blit_req_t  req;
  blit_desc_t desc;
  logic       bad_size, bad_stride, bad_align, req_ok;
  logic       accept, start, busy, error_q;

  assign req = '{mem_addr: req_mem_addr, fb_addr: req_fb_addr, line_len: req_line_len,
                 lines: req_lines, mem_stride: req_mem_stride, fb_stride: req_fb_stride,
                 count_only: req_count_only};

  blit_req_check #(
    .MAX_LINES(MAX_LINES), .MAX_MSTRIDE(MAX_MSTRIDE), .PAGE_BITS(PAGE_BITS)
  ) u_check (
    .mem_addr(req_mem_addr), .fb_addr(req_fb_addr), .line_len(req_line_len),
    .lines(req_lines), .mem_stride(req_mem_stride), .fb_stride(req_fb_stride),
    .bad_size(bad_size), .bad_stride(bad_stride), .bad_align(bad_align), .req_ok(req_ok)
  );

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign start     = accept && req_ok;

  blit_walk #(.PAGE_BITS(PAGE_BITS), .LINK_BASE(LINK_BASE)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .req(req), .out_ready(desc_ready),
    .busy(busy), .emit_valid(desc_valid), .desc(desc), .walk_done(done),
    .count(desc_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) error_q <= 1'b0;
    else        error_q <= accept && !req_ok;
  end
  assign error = error_q;

  assign desc_mem_addr = desc.mem;
  assign desc_dev_addr = desc.dev;
  assign desc_size     = desc.size;
  assign desc_link     = desc.link;

  // R8: a refusal produces neither output nor completion
  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (!desc_valid && !done));

  // R12: no request is taken while descriptors are pending
  a_r12_busy_block: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> !req_ready);

  // R4: a started real pass opens with the tail mark
  a_r4_first_link: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_ok && !req_count_only) |=> (desc_valid && desc_link == 32'h2));

  // R6: a misaligned request never starts a walk
  a_r6_align_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bad_align) |=> (error && !desc_valid));

endmodule

// File: tb/blit_desc_gen_test.sv
module blit_desc_gen_test;
  localparam logic [31:0] BASE = 32'h0001_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_count_only = 1'b0, desc_ready = 1'b0;
  logic [31:0] req_mem_addr = '0, req_fb_addr = '0, req_fb_stride = '0;
  logic [15:0] req_line_len = '0, req_lines = '0, req_mem_stride = '0;
  logic req_ready, desc_valid, done, error;
  logic [31:0] desc_mem_addr, desc_dev_addr, desc_size, desc_link, desc_count;

  int errors = 0, checks = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  blit_desc_gen uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mem_addr(req_mem_addr), .req_fb_addr(req_fb_addr), .req_line_len(req_line_len),
    .req_lines(req_lines), .req_mem_stride(req_mem_stride), .req_fb_stride(req_fb_stride),
    .req_count_only(req_count_only), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_mem_addr(desc_mem_addr), .desc_dev_addr(desc_dev_addr), .desc_size(desc_size),
    .desc_link(desc_link), .done(done), .error(error), .desc_count(desc_count)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit refused(input longint ma, fa, len, lines, ms, fs);
    longint mag;
    mag = (fs < 0) ? -fs : fs;
    if (lines < 1 || len < 1 || lines > 2048) return 1;           // R5
    if (ms > 8192 || (ms >= len && ms - len >= 4096)) return 1;   // R5
    if (ms < len || mag < len) return 1;                          // R7
    if ((ma % 16) != 0 || (ms % 16) != 0) return 1;               // R6
    if ((fa & 3) != 0 || (fs & 3) != 0) return 1;                 // R6
    return 0;
  endfunction

  task automatic run(input longint ma, fa, len, lines, ms, fs, input bit co,
                     input bit poke, input string tag);
    longint qm[$], qd[$], qs[$], ql[$];
    longint m, f, left, c, k, n;
    bit exp_err, stalled, seen_done;
    longint pm, pd, ps, pl;
    exp_err = refused(ma, fa, len, lines, ms, fs);
    k = 0;
    if (!exp_err) begin
      for (longint ln = 0; ln < lines; ln++) begin
        m = ma + ln * ms; f = fa + ln * fs; left = len;
        while (left > 0) begin
          c = 4096 - (m % 4096);
          if (left < c) c = left;
          qm.push_back(m & 32'hFFFF_FFFF); qd.push_back(f & 32'hFFFF_FFFF);
          qs.push_back(c);
          ql.push_back(k == 0 ? 2 : ((BASE + 16 * (k - 1)) & 32'hFFFF_FFFF));
          m += c; f += c; left -= c; k++;
        end
      end
    end
    n = k;
    @(negedge clk);
    check(req_ready == 1'b1, "R12", {tag, " ready when idle"}, req_ready, 1);
    req_valid = 1'b1; req_mem_addr = ma[31:0]; req_fb_addr = fa[31:0];
    req_line_len = len[15:0]; req_lines = lines[15:0]; req_mem_stride = ms[15:0];
    req_fb_stride = fs[31:0]; req_count_only = co;
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_err) begin
      check(error == 1'b1, "R8", {tag, " error pulse"}, error, 1);
      check(!desc_valid && !done, "R8", {tag, " quiet on refusal"}, {desc_valid, done}, 0);
      @(negedge clk);
      check(error == 1'b0 && !desc_valid, "R8", {tag, " error one cycle"}, error, 0);
      return;
    end
    if (co) begin
      bit bad;
      bad = 0;
      for (longint i = 1; i <= n; i++) begin
        if (desc_valid || done) bad = 1;
        @(negedge clk);
      end
      check(!bad, "R11", {tag, " silent while counting"}, bad, 0);
      check(done == 1'b1, "R11", {tag, " done after N+1"}, done, 1);
      check(desc_count == n[31:0], "R11", {tag, " count"}, desc_count, n);
      @(negedge clk);
      check(done == 1'b0, "R10", {tag, " done pulse"}, done, 0);
      return;
    end
    stalled = 0; seen_done = 0; pm = 0; pd = 0; ps = 0; pl = 0;
    for (int cyc = 0; cyc < 40000 && !seen_done; cyc++) begin
      if (done) begin
        seen_done = 1;
        check(qm.size() == 0, "R10", {tag, " done only after last"}, qm.size(), 0);
        check(desc_count == n[31:0], "R10", {tag, " count"}, desc_count, n);
      end else begin
        if (qm.size() == 0)
          check(0, "R10", {tag, " done late"}, done, 1);
        if (poke) begin
          req_valid = (cyc == 1);
          req_lines = 16'd7;
          if (cyc == 1) check(req_ready == 1'b0, "R12", {tag, " busy refuses"}, req_ready, 0);
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        desc_ready = lfsr[0] | lfsr[1];
        if (desc_valid) begin
          if (stalled)
            check(desc_mem_addr == pm && desc_dev_addr == pd && desc_size == ps &&
                  desc_link == pl, "R9", {tag, " stall stable"}, desc_mem_addr, pm);
          if (desc_ready && qm.size() > 0) begin
            check(desc_mem_addr == qm[0], "R2", {tag, " mem addr"}, desc_mem_addr, qm[0]);
            check(desc_dev_addr == qd[0], "R2", {tag, " dev addr"}, desc_dev_addr, qd[0]);
            check(desc_size == qs[0], "R1", {tag, " size"}, desc_size, qs[0]);
            check(desc_link == ql[0], "R4", {tag, " link"}, desc_link, ql[0]);
            void'(qm.pop_front()); void'(qd.pop_front());
            void'(qs.pop_front()); void'(ql.pop_front());
          end
          stalled = !desc_ready;
          pm = desc_mem_addr; pd = desc_dev_addr; ps = desc_size; pl = desc_link;
        end else begin
          if (!stalled && qm.size() > 0 && cyc > 0)
            check(0, "R3", {tag, " descriptor missing"}, desc_valid, 1);
          if (stalled) check(0, "R9", {tag, " valid dropped"}, desc_valid, 1);
          stalled = 0;
        end
      end
      @(negedge clk);
    end
    req_valid = 1'b0; desc_ready = 1'b0;
    check(seen_done, "R10", {tag, " done seen"}, seen_done, 1);
    check(!done && !desc_valid, "R10", {tag, " idle after done"}, {done, desc_valid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready && !desc_valid && !done && !error, "R12", "reset state",
          {req_ready, desc_valid, done, error}, 4'b1000);
    rst_n = 1'b1;
    // R2 R3 basic multi-line
    run(32'h1000_0000, 32'h100, 64, 3, 128, 256, 0, 0, "basic");
    // R1 page splits mid-line
    run(32'h0000_0FC0, 32'h2000, 256, 2, 512, 512, 0, 0, "split");
    // R1 line ending exactly at a page boundary
    run(32'h0000_0F00, 32'h0, 256, 3, 256, 256, 0, 0, "edge");
    // R1 lines spanning three pages, max stride
    run(32'h2000_0F00, 32'h40, 8000, 2, 8192, 8192, 0, 0, "long");
    // R2 negative frame-buffer stride, with R12 poke while busy
    run(32'h0030_0000, 32'h0010_0000, 512, 4, 512, -1024, 0, 1, "flip");
    // R11 count-only
    run(32'h2000_0F00, 32'h40, 8000, 2, 8192, 8192, 1, 0, "count");
    run(32'h0, 32'h0, 16, 2048, 16, 16, 1, 0, "maxlines");
    // R5 size rules
    run(32'h0, 32'h0, 64, 0, 64, 64, 0, 0, "R5 zero lines");
    run(32'h0, 32'h0, 0, 4, 64, 64, 0, 0, "R5 zero len");
    run(32'h0, 32'h0, 16, 2049, 16, 16, 0, 0, "R5 lines");
    run(32'h0, 32'h0, 4112, 1, 8208, 4112, 0, 0, "R5 stride");
    run(32'h0, 32'h0, 64, 2, 4160, 64, 0, 0, "R5 gap");
    run(32'h0, 32'h0, 64, 2, 4144, 64, 0, 0, "R5 gap ok");
    // R6 alignment
    run(32'h8, 32'h0, 64, 2, 64, 64, 0, 0, "R6 mem addr");
    run(32'h0, 32'h0, 64, 2, 72, 64, 0, 0, "R6 mem stride");
    run(32'h0, 32'h2, 64, 2, 64, 64, 0, 0, "R6 fb addr");
    run(32'h0, 32'h0, 64, 2, 64, 66, 0, 0, "R6 fb stride");
    // R7 stride relations
    run(32'h0, 32'h0, 64, 2, 48, 64, 0, 0, "R7 mem stride");
    run(32'h0, 32'h0, 64, 2, 64, -32, 0, 0, "R7 fb stride");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule